// File: doc/BRIEF.md
# Bus-Switch Channel Select Slave

This block is a two-wire serial slave that owns the single control byte of a four-way downstream bus switch. It watches oversampled clock and data lines, cleans them with a glitch filter, and recognises start and stop conditions. It answers one 7-bit address. The upper five bits of that address are fixed and the lower two come from strap inputs. A master writes the channel selection and reads back a status byte. The status byte merges live per-channel interrupt flags with the selection that is currently in force.

The four channel-enable outputs never change in the middle of a transaction. A selection that arrives over the bus is held as pending. It is copied to the outputs only when a stop condition closes the transfer, so every downstream segment is idle when it is connected. A synchronous system reset and a separate external active-low reset both return everything to the deselected, idle state.

Top module: `i2c_chansel`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal 1,1,1,0,0,strap[1],strap[0]. Bit 0 of that byte is 1 for a read and 0 for a write. A mismatched address gets no acknowledge. The data bytes that follow it are ignored and leave chan_en unchanged.
- R2: After a matching address, the slave pulls SDA low (sda_oe=1) during the ninth clock. For a write it does the same for every data byte that follows.
- R3: When several data bytes arrive in one write, only the last one received before the stop condition sets the selection.
- R4: Bit i of a written byte (i = 0..3) enables channel i when it is 1, and any combination is allowed. chan_en keeps its previous value until a stop condition is seen, and then takes the new value.
- R5: A read returns one byte, MSB first. Bit 4+i is 1 when irq_n[i] is low. Bits 3..0 equal the current chan_en.
- R6: When the master answers the read byte with NACK, the slave leaves SDA released until the next start or stop.
- R7: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks is ignored. FILT_CYC = SPIKE_NS/CLK_PERIOD_NS + 1.
- R8: Holding rst high, or bus_rst_n low for at least three clocks, clears chan_en and any pending selection, releases SDA and returns the slave to idle.
- R9: A repeated start restarts address reception. A pending selection is not applied at the repeated start. It is applied at the next stop condition.
- R10: Bits 7..4 of a written byte are ignored. A later read shows only interrupt status in those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_n | input | 1 | External active-low reset, asynchronous to clk |
| strap | input | 2 | Address strap bits, placed in address bits 1..0 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| irq_n | input | 4 | Active-low interrupt request, one per channel |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| chan_en | output | 4 | Channel enables in force, bit i for channel i |

## Verification
The bench uses the default parameters: a 10 ns clock period and a 50 ns spike limit, which gives a six-cycle filter. The fixed address bits are 11100 and the straps are tied to 2'b10. With these settings a 4-cycle SCL spike falls below the filter limit, so filter rejection can be tested directly inside a live write. A bus bit period of 100 clocks leaves enough room around the filter and synchroniser latency to observe pending selections, repeated starts and the release of SDA after a NACK.

// File: rtl/i2c_chansel_pkg.sv
`timescale 1ns/1ps
package i2c_chansel_pkg;
  localparam int unsigned NCH    = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } st_t;
endpackage

// File: rtl/i2c_chansel_filt.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by a persistence filter: the output
// follows the input only after FILT_CYC consecutive differing samples.
module i2c_chansel_filt #(
  parameter int unsigned FILT_CYC = 6,
  parameter bit          RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      sync_q <= {2{RST_VAL}};
      dout   <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] != dout) begin
        if (cnt_q == CNT_LAST) begin
          dout  <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R7: a new output level must have been present at the synchroniser
  p_filt_follow_r7: assert property (@(posedge clk) disable iff (clr)
    (dout != $past(dout)) |-> ($past(sync_q[1]) == dout));
  // R7: a change only happens when the persistence count is complete
  p_filt_persist_r7: assert property (@(posedge clk) disable iff (clr)
    (dout != $past(dout)) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/i2c_chansel_cond.sv
`timescale 1ns/1ps
// Detects start/stop conditions and clock edges on the filtered lines.
module i2c_chansel_cond (
  input  logic clk,
  input  logic clr,
  input  logic scl,
  input  logic sda,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    start_p = scl & scl_q & sda_q & ~sda;
    stop_p  = scl & scl_q & ~sda_q & sda;
    rise_p  = scl & ~scl_q;
    fall_p  = ~scl & scl_q;
  end
endmodule

// File: rtl/i2c_chansel_fsm.sv
`timescale 1ns/1ps
// Byte engine: address match, acknowledge, write capture, read shift-out
// and the pending-to-active selection transfer at stop.
module i2c_chansel_fsm
  import i2c_chansel_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b11100
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           sda,
  input  logic           start_p,
  input  logic           stop_p,
  input  logic           rise_p,
  input  logic           fall_p,
  input  logic [1:0]     strap,
  input  logic [NCH-1:0] irq_stat,
  output logic           sda_oe,
  output logic [NCH-1:0] chan_en
);
  localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

  st_t              st;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [3:0]        cnt_q;
  logic              rw_q, mack_q;
  logic [NCH-1:0]    pend_q;
  logic              pend_v;
  logic [BYTE_W-1:0] rd_byte;

  assign rd_byte = {irq_stat, chan_en};

  always_ff @(posedge clk) begin
    if (clr) begin
      st      <= ST_IDLE;
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= '0;
      pend_v  <= 1'b0;
      sda_oe  <= 1'b0;
      chan_en <= '0;
    end else if (start_p) begin
      st     <= ST_ADDR;
      cnt_q  <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      if (pend_v) begin
        chan_en <= pend_q;
        pend_v  <= 1'b0;
      end
    end else begin
      case (st)
        ST_ADDR, ST_WDATA: begin
          if (rise_p) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda};
            cnt_q <= cnt_q + 1'b1;
          end else if (fall_p && cnt_q == BITS_DONE) begin
            cnt_q <= '0;
            if (st == ST_ADDR) begin
              if (rx_q[7:1] == {ADDR_FIXED, strap}) begin
                sda_oe <= 1'b1;
                rw_q   <= rx_q[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_WAIT;
              end
            end else begin
              pend_q <= rx_q[NCH-1:0];
              pend_v <= 1'b1;
              sda_oe <= 1'b1;
              st     <= ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (fall_p) begin
            if (rw_q) begin
              sda_oe <= ~rd_byte[BYTE_W-1];
              tx_q   <= {rd_byte[BYTE_W-2:0], 1'b0};
              cnt_q  <= 4'd1;
              st     <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              cnt_q  <= '0;
              st     <= ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (fall_p) begin
            sda_oe <= 1'b0;
            cnt_q  <= '0;
            st     <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (fall_p) begin
            if (cnt_q == BITS_DONE) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sda_oe <= ~tx_q[BYTE_W-1];
              tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (rise_p) begin
            mack_q <= ~sda;
          end else if (fall_p) begin
            if (mack_q) begin
              sda_oe <= ~rd_byte[BYTE_W-1];
              tx_q   <= {rd_byte[BYTE_W-2:0], 1'b0};
              cnt_q  <= 4'd1;
              st     <= ST_RDATA;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1: an unmatched address never leads to SDA drive
  p_wait_quiet_r1: assert property (@(posedge clk) disable iff (clr)
    (st == ST_WAIT) |-> !sda_oe);
  // R2: SDA is only driven in acknowledge or read-data phases
  p_oe_phase_r2: assert property (@(posedge clk) disable iff (clr)
    sda_oe |-> (st == ST_AACK || st == ST_WACK || st == ST_RDATA));
  // R4: the enables move only in the cycle after a stop condition
  p_en_at_stop_r4: assert property (@(posedge clk) disable iff (clr)
    (chan_en != $past(chan_en)) |-> $past(stop_p));
  // R6: SDA is released while the master answers the read byte
  p_rack_release_r6: assert property (@(posedge clk) disable iff (clr)
    (st == ST_RACK) |-> !sda_oe);
  // R9: any start restarts address reception, enables untouched
  p_restart_r9: assert property (@(posedge clk) disable iff (clr)
    start_p |=> (st == ST_ADDR && !sda_oe && $stable(chan_en)));
endmodule

// File: rtl/i2c_chansel.sv
`timescale 1ns/1ps
module i2c_chansel
  import i2c_chansel_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPIKE_NS      = 50,
  parameter logic [4:0]  ADDR_FIXED    = 5'b11100
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_rst_n,
  input  logic [1:0]     strap,
  input  logic           scl_i,
  input  logic           sda_i,
  input  logic [NCH-1:0] irq_n,
  output logic           sda_oe,
  output logic [NCH-1:0] chan_en
);
  localparam int unsigned FILT_CYC = SPIKE_NS / CLK_PERIOD_NS + 1;
  localparam int unsigned NLINE    = 2;

  logic [1:0]     brst_q;
  logic           clr;
  logic [NCH-1:0] irq_q1, irq_q2;
  logic [NLINE-1:0] line_raw, line_flt;
  logic start_p, stop_p, rise_p, fall_p;

  always_ff @(posedge clk) begin
    if (rst) brst_q <= 2'b11;
    else     brst_q <= {brst_q[0], bus_rst_n};
  end

  assign clr = rst | ~brst_q[1];

  always_ff @(posedge clk) begin
    if (clr) begin
      irq_q1 <= '1;
      irq_q2 <= '1;
    end else begin
      irq_q1 <= irq_n;
      irq_q2 <= irq_q1;
    end
  end

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2c_chansel_filt #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .clr  (clr),
      .din  (line_raw[g]),
      .dout (line_flt[g])
    );
  end

  i2c_chansel_cond u_cond (
    .clk     (clk),
    .clr     (clr),
    .scl     (line_flt[0]),
    .sda     (line_flt[1]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  i2c_chansel_fsm #(.ADDR_FIXED(ADDR_FIXED)) u_fsm (
    .clk      (clk),
    .clr      (clr),
    .sda      (line_flt[1]),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .strap    (strap),
    .irq_stat (~irq_q2),
    .sda_oe   (sda_oe),
    .chan_en  (chan_en)
  );

  // R8: the cycle after an external reset sample, outputs are cleared
  p_rst_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!brst_q[1]) |-> (chan_en == '0 && !sda_oe));
endmodule

// File: tb/sim_i2c_chansel.sv
`timescale 1ns/1ps
module sim_i2c_chansel;
  localparam int Q = 25;
  localparam int H = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] irq_n = 4'hF;
  logic       sda_oe;
  logic [3:0] chan_en;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_chansel u0 (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .strap(strap),
    .scl_i(scl_m), .sda_i(sda_bus), .irq_n(irq_n),
    .sda_oe(sda_oe), .chan_en(chan_en)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int cyc = 0;

  typedef struct { logic [3:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic [3:0] last_en = 4'h0;

  task automatic chk(string req, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_exp(logic [3:0] v, string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: every change of chan_en must match the next expected item
  always @(negedge clk) begin
    if (mon_on && chan_en !== last_en) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected chan_en change", int'(chan_en), int'(last_en));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, int'(chan_en), int'(e.val));
      end
      last_en = chan_en;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(bit b, bit glitch);
    sda_m = b;
    wt(Q);
    if (glitch) begin
      scl_m = 1'b1; wt(4); scl_m = 1'b0; wt(Q);
    end
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_ack(output bit a);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H/2);
    a = sda_bus;
    wt(H/2);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic wr_byte(logic [7:0] v, bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
    get_ack(ack);
  endtask

  task automatic rd_byte(output logic [7:0] v, input bit nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(H/2);
      v[i] = sda_bus;
      wt(H/2);
      scl_m = 1'b0; wt(Q);
    end
    put_bit(nack, 1'b0);
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  initial begin
    bit a;
    logic [7:0] rv;
    int seen;

    wt(5);
    rst = 1'b0;
    wt(20);
    chk("R8 reset chan_en", int'(chan_en), 0);
    chk("R8 reset sda_oe", int'(sda_oe), 0);
    mon_on = 1'b1;

    // Single write 0x05: channels 0 and 2
    do_start();
    wr_byte(8'hE4, 1'b0, a); chk("R2 write address ack", int'(a), 0);
    wr_byte(8'h05, 1'b0, a); chk("R2 data ack", int'(a), 0);
    wt(40);
    chk("R4 enables held before stop", int'(chan_en), 0);
    push_exp(4'h5, "R4 applied at stop");
    do_stop();
    wt(40);

    // Multi-byte write: only last byte is kept
    do_start();
    wr_byte(8'hE4, 1'b0, a);
    wr_byte(8'h03, 1'b0, a); chk("R3 first byte ack", int'(a), 0);
    wr_byte(8'h0C, 1'b0, a); chk("R3 second byte ack", int'(a), 0);
    wr_byte(8'h09, 1'b0, a); chk("R3 third byte ack", int'(a), 0);
    push_exp(4'h9, "R3 last byte kept");
    do_stop();
    wt(40);

    // Read with interrupts on channels 0 and 2, then NACK
    irq_n = 4'b1010;
    wt(10);
    do_start();
    wr_byte(8'hE5, 1'b0, a); chk("R2 read address ack", int'(a), 0);
    rd_byte(rv, 1'b1);
    chk("R5 status byte", int'(rv), 'h59);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      wt(1);
      if (sda_oe) seen++;
    end
    chk("R6 SDA released after NACK", seen, 0);
    do_stop();
    irq_n = 4'hF;
    wt(40);

    // Upper nibble of a write is ignored
    do_start();
    wr_byte(8'hE4, 1'b0, a);
    wr_byte(8'hF6, 1'b0, a);
    push_exp(4'h6, "R10 low nibble applied");
    do_stop();
    wt(40);
    do_start();
    wr_byte(8'hE5, 1'b0, a);
    rd_byte(rv, 1'b1);
    chk("R10 upper bits show irq only", int'(rv), 'h06);
    do_stop();
    wt(40);

    // Wrong address (straps differ): no ack, no change
    do_start();
    wr_byte(8'hE0, 1'b0, a); chk("R1 mismatched address nack", int'(a), 1);
    wr_byte(8'h0F, 1'b0, a); chk("R1 ignored data nack", int'(a), 1);
    do_stop();
    wt(40);
    chk("R1 chan_en unchanged", int'(chan_en), 'h6);

    // Repeated start keeps selection pending
    do_start();
    wr_byte(8'hE4, 1'b0, a);
    wr_byte(8'h0B, 1'b0, a);
    do_rstart();
    wr_byte(8'hE5, 1'b0, a); chk("R9 address after repeated start", int'(a), 0);
    rd_byte(rv, 1'b1);
    chk("R9 read shows old selection", int'(rv), 'h06);
    chk("R9 chan_en not yet applied", int'(chan_en), 'h6);
    push_exp(4'hB, "R9 applied at later stop");
    do_stop();
    wt(40);

    // Short SCL spikes inside each bit must be filtered
    do_start();
    wr_byte(8'hE4, 1'b1, a); chk("R7 address ack with spikes", int'(a), 0);
    wr_byte(8'h0A, 1'b1, a); chk("R7 data ack with spikes", int'(a), 0);
    push_exp(4'hA, "R7 spikes rejected");
    do_stop();
    wt(40);

    // External reset clears the selection
    push_exp(4'h0, "R8 external reset clears");
    bus_rst_n = 1'b0;
    wt(6);
    bus_rst_n = 1'b1;
    wt(20);
    chk("R8 sda_oe after external reset", int'(sda_oe), 0);

    chk("R4 all expected changes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule